// File: doc/BRIEF.md
# Three-Level Surface Translation Walker

The walker turns a 48-bit main-surface virtual address into the address of the auxiliary data that belongs to it, together with the format descriptor stored beside that address. It finds them by reading a three-level table tree in memory: a top table located by a base input, a middle table, and a leaf table. The middle and leaf tables are each located through a pointer held in the entry one level up.

A client presents a request on a valid/ready handshake. The walker issues one 64-bit memory read per level over a simple request/response port, strictly in order. At each level it tests the entry's valid bit and stops at the first entry that is not valid. The result holds the auxiliary address and the leaf's format, plane, depth and tile-mode fields. It also flags a miss together with the level where the miss happened, or a fault for a leaf that names a reserved tile mode. Only one walk is in flight at a time. The result stays on the outputs until the client takes it.

Top module: `surf_xlate_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both `res_valid_o` and `mem_req_valid_o` are 0.
- R2: Each read goes to the current table base plus 8 times that level's index. The top index is vaddr[47:36], the middle index is vaddr[35:24] and the leaf index is vaddr[23:16]. Bits 15:0 of the address do not affect any read.
- R3: The middle-table base comes from a valid top entry. It is entry bits 47:15, with bits 14:0 forced to zero and bit 47 copied into bits 63:48. Entry bits 63:48 and 14:1 are ignored.
- R4: The leaf-table base comes from a valid middle entry. It is entry bits 47:13, with bits 12:0 forced to zero and bit 47 copied into bits 63:48.
- R5: A valid leaf gives the following result fields. `res_aux_o` is entry bits 47:8, with bits 7:0 zero. `res_fmt_o` is bits 63:58, `res_chroma_o` is bit 57 (0 luma, 1 chroma), `res_depth_o` is bits 56:54 and `res_tile_o` is bits 53:52 (0 Ys, 1 Y). On a hit, `res_level_o` is 2.
- R6: An entry with bit 0 clear ends the walk at its level, even when its other bits are non-zero. The result then has `res_miss_o`=1 and zeroed data fields. `res_level_o` gives the level that missed: 0 top, 1 middle, 2 leaf. Exactly level+1 reads are made.
- R7: A valid leaf whose tile mode is 2 or 3 gives `res_fault_o`=1, `res_miss_o`=0 and `res_level_o`=2, and the leaf fields are still reported. Tile modes 0 and 1 give `res_fault_o`=0.
- R8: `req_ready_o` is 0 from the cycle after a request is accepted until the cycle after its result is consumed. While `res_valid_o` is 1 and `res_ready_i` is 0, all result outputs stay stable, and no new request is accepted or read.
- R9: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request stays asserted and `mem_req_addr_o` stays stable. A walk makes at most three reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base_i | input | 64 | Top-table base address, sampled when a request is accepted |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vaddr_i | input | 48 | Main-surface virtual address to translate |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 64 | Byte address of the 64-bit entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read data (one table entry) |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Client consumes the result |
| res_aux_o | output | 48 | Auxiliary data address |
| res_fmt_o | output | 6 | Format code |
| res_chroma_o | output | 1 | Plane select: 0 luma, 1 chroma |
| res_depth_o | output | 3 | Depth code |
| res_tile_o | output | 2 | Tile mode |
| res_miss_o | output | 1 | Walk ended on an entry that is not valid |
| res_fault_o | output | 1 | Leaf names a reserved tile mode |
| res_level_o | output | 2 | Level of the last entry read (0 top, 1 middle, 2 leaf) |

## Verification
The case of interest is a finished result that is still held while the next lookup is already waiting at the request port. The bench provokes it by keeping `res_ready_i` low for several cycles after a result appears, while it presents a second request with a different table path. It checks that the request is not taken, that no read goes out and that every result field holds. It then releases the result and checks that the second walk reads its own path and returns its own leaf. A second overlap is a stalled memory request at every level, judged by the stability of the read address and by the exact number of stalled cycles and reads.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int VA_W      = 48;
    localparam int ADDR_W    = 64;
    localparam int ENT_W     = 64;
    localparam int ENT_SHIFT = $clog2(ENT_W / 8);

    localparam int TOP_LSB   = 36;
    localparam int TOP_BITS  = 12;
    localparam int MID_LSB   = 24;
    localparam int MID_BITS  = 12;
    localparam int LEAF_LSB  = 16;
    localparam int LEAF_BITS = 8;
    localparam int IDX_W     = (TOP_BITS > MID_BITS) ? TOP_BITS : MID_BITS;

    localparam int MID_ALIGN  = 15;
    localparam int LEAF_ALIGN = 13;
    localparam int AUX_ALIGN  = 8;

    localparam int FMT_LSB   = 58;
    localparam int FMT_W     = 6;
    localparam int PLANE_BIT = 57;
    localparam int DEPTH_LSB = 54;
    localparam int DEPTH_W   = 3;
    localparam int TILE_LSB  = 52;
    localparam int TILE_W    = 2;

    typedef enum logic [1:0] {
        LVL_TOP  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_LEAF = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic [FMT_W-1:0]   fmt;
        logic               chroma;
        logic [DEPTH_W-1:0] depth;
        logic [TILE_W-1:0]  tile;
        logic [VA_W-1:0]    aux;
    } leaf_t;
endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
    import xw_pkg::*;
(
    input  lvl_e              lvl_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [VA_W-1:0]   vaddr_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [IDX_W-1:0] idx;
    logic [15:0]      unused_low;

    assign unused_low = vaddr_i[LEAF_LSB-1:0];

    always_comb begin
        case (lvl_i)
            LVL_TOP: idx = IDX_W'(vaddr_i[TOP_LSB +: TOP_BITS]);
            LVL_MID: idx = IDX_W'(vaddr_i[MID_LSB +: MID_BITS]);
            default: idx = IDX_W'(vaddr_i[LEAF_LSB +: LEAF_BITS]);
        endcase
        addr_o = base_i + (ADDR_W'(idx) << ENT_SHIFT);
    end
endmodule

// File: rtl/xw_entry_dec.sv
module xw_entry_dec
    import xw_pkg::*;
(
    input  lvl_e              lvl_i,
    input  logic [ENT_W-1:0]  ent_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] next_base_o,
    output leaf_t             leaf_o,
    output logic              rsvd_tile_o
);
    logic [VA_W-1:0] raw;
    logic            unused_bits;

    assign unused_bits = ^{ent_i[TILE_LSB-1:VA_W], ent_i[AUX_ALIGN-1:1]};
    assign valid_o     = ent_i[0];

    always_comb begin
        raw = ent_i[VA_W-1:0];
        if (lvl_i == LVL_TOP) begin
            raw[MID_ALIGN-1:0] = '0;
        end else begin
            raw[LEAF_ALIGN-1:0] = '0;
        end
        next_base_o = {{(ADDR_W-VA_W){raw[VA_W-1]}}, raw};

        leaf_o.fmt    = ent_i[FMT_LSB +: FMT_W];
        leaf_o.chroma = ent_i[PLANE_BIT];
        leaf_o.depth  = ent_i[DEPTH_LSB +: DEPTH_W];
        leaf_o.tile   = ent_i[TILE_LSB +: TILE_W];
        leaf_o.aux    = {ent_i[VA_W-1:AUX_ALIGN], {AUX_ALIGN{1'b0}}};
        rsvd_tile_o   = ent_i[TILE_LSB + TILE_W - 1];
    end
endmodule

// File: rtl/surf_xlate_walker.sv
module surf_xlate_walker
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [VA_W-1:0]   req_vaddr_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [ENT_W-1:0]  mem_rsp_data_i,
    output logic              res_valid_o,
    input  logic              res_ready_i,
    output logic [VA_W-1:0]   res_aux_o,
    output logic [FMT_W-1:0]  res_fmt_o,
    output logic              res_chroma_o,
    output logic [DEPTH_W-1:0] res_depth_o,
    output logic [TILE_W-1:0] res_tile_o,
    output logic              res_miss_o,
    output logic              res_fault_o,
    output logic [1:0]        res_level_o
);
    typedef struct packed {
        st_e               st;
        lvl_e              lvl;
        logic [ADDR_W-1:0] base;
        logic [VA_W-1:0]   vaddr;
        leaf_t             leaf;
        logic              miss;
        logic              fault;
    } walk_t;

    walk_t             w_d, w_q;
    logic              dec_valid;
    logic [ADDR_W-1:0] dec_next;
    leaf_t             dec_leaf;
    logic              dec_rsvd;

    xw_addr_gen u_addr (
        .lvl_i   (w_q.lvl),
        .base_i  (w_q.base),
        .vaddr_i (w_q.vaddr),
        .addr_o  (mem_req_addr_o)
    );

    xw_entry_dec u_dec (
        .lvl_i       (w_q.lvl),
        .ent_i       (mem_rsp_data_i),
        .valid_o     (dec_valid),
        .next_base_o (dec_next),
        .leaf_o      (dec_leaf),
        .rsvd_tile_o (dec_rsvd)
    );

    always_comb begin
        w_d = w_q;
        case (w_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    w_d.st    = ST_ISSUE;
                    w_d.lvl   = LVL_TOP;
                    w_d.base  = tbl_base_i;
                    w_d.vaddr = req_vaddr_i;
                    w_d.leaf  = '0;
                    w_d.miss  = 1'b0;
                    w_d.fault = 1'b0;
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready_i) begin
                    w_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (!dec_valid) begin
                        w_d.st   = ST_DONE;
                        w_d.miss = 1'b1;
                    end else if (w_q.lvl != LVL_LEAF) begin
                        w_d.st   = ST_ISSUE;
                        w_d.base = dec_next;
                        w_d.lvl  = (w_q.lvl == LVL_TOP) ? LVL_MID : LVL_LEAF;
                    end else begin
                        w_d.st    = ST_DONE;
                        w_d.leaf  = dec_leaf;
                        w_d.fault = dec_rsvd;
                    end
                end
            end
            default: begin
                if (res_ready_i) begin
                    w_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{st: ST_IDLE, lvl: LVL_TOP, default: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign req_ready_o     = (w_q.st == ST_IDLE);
    assign mem_req_valid_o = (w_q.st == ST_ISSUE);
    assign res_valid_o     = (w_q.st == ST_DONE);
    assign res_aux_o       = w_q.leaf.aux;
    assign res_fmt_o       = w_q.leaf.fmt;
    assign res_chroma_o    = w_q.leaf.chroma;
    assign res_depth_o     = w_q.leaf.depth;
    assign res_tile_o      = w_q.leaf.tile;
    assign res_miss_o      = w_q.miss;
    assign res_fault_o     = w_q.fault;
    assign res_level_o     = w_q.lvl;
endmodule

// File: rtl/xw_checker.sv
module xw_checker
    import xw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              mem_req_valid_o,
    input logic              mem_req_ready_i,
    input logic [ADDR_W-1:0] mem_req_addr_o,
    input logic              res_valid_o,
    input logic              res_ready_i,
    input logic [VA_W-1:0]   res_aux_o,
    input logic [FMT_W-1:0]  res_fmt_o,
    input logic              res_chroma_o,
    input logic [DEPTH_W-1:0] res_depth_o,
    input logic [TILE_W-1:0] res_tile_o,
    input logic              res_miss_o,
    input logic              res_fault_o,
    input logic [1:0]        res_level_o
);
    logic [2:0] reads_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reads_q <= '0;
        end else if (req_valid_i && req_ready_o) begin
            reads_q <= '0;
        end else if (mem_req_valid_o && mem_req_ready_i) begin
            reads_q <= reads_q + 3'd1;
        end
    end

    assert_entry_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> (mem_req_addr_o[ENT_SHIFT-1:0] == '0));

    assert_read_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (reads_q == ({1'b0, res_level_o} + 3'd1)));

    assert_fault_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_fault_o) |-> (!res_miss_o && res_level_o == 2'd2 && res_tile_o[1]));

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o || res_valid_o) |-> !req_ready_o);

    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable({res_aux_o, res_fmt_o,
            res_chroma_o, res_depth_o, res_tile_o, res_miss_o, res_fault_o, res_level_o})));

    assert_mem_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    assert_max_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> (reads_q < 3'd3));
endmodule

bind surf_xlate_walker xw_checker u_xw_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .res_valid_o     (res_valid_o),
    .res_ready_i     (res_ready_i),
    .res_aux_o       (res_aux_o),
    .res_fmt_o       (res_fmt_o),
    .res_chroma_o    (res_chroma_o),
    .res_depth_o     (res_depth_o),
    .res_tile_o      (res_tile_o),
    .res_miss_o      (res_miss_o),
    .res_fault_o     (res_fault_o),
    .res_level_o     (res_level_o)
);

// File: tb/tb_surf_xlate_walker.sv
`timescale 1ns/1ps
module tb_surf_xlate_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tbl_base = 64'h0000_1234_5600_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic        mem_req_valid;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [47:0] res_aux;
    logic [5:0]  res_fmt;
    logic        res_chroma;
    logic [2:0]  res_depth;
    logic [1:0]  res_tile;
    logic        res_miss;
    logic        res_fault;
    logic [1:0]  res_level;

    always #5 clk = ~clk;

    surf_xlate_walker dut (
        .clk(clk), .rst_n(rst_n), .tbl_base_i(tbl_base),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
        .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_ready),
        .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
        .mem_rsp_data_i(mem_rsp_data), .res_valid_o(res_valid), .res_ready_i(res_ready),
        .res_aux_o(res_aux), .res_fmt_o(res_fmt), .res_chroma_o(res_chroma),
        .res_depth_o(res_depth), .res_tile_o(res_tile), .res_miss_o(res_miss),
        .res_fault_o(res_fault), .res_level_o(res_level)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [63:0] mem [logic [63:0]];
    logic [63:0] rd_log [8];
    int          rd_cnt = 0;
    int          stall_per = 0;
    int          stall_left = 0;
    int          stall_seen = 0;
    logic        seen = 1'b0;
    logic        addr_moved = 1'b0;
    logic        pend = 1'b0;
    logic [63:0] pend_addr = '0;
    logic [63:0] first_addr = '0;

    localparam logic [63:0] MB  = 64'h0000_0002_0000_8000;
    localparam logic [63:0] LB  = 64'h0000_0003_0000_6000;
    localparam logic [63:0] MB2 = 64'hFFFF_8000_0001_0000;
    localparam logic [63:0] LB2 = 64'hFFFF_8000_0002_0000;

    function automatic logic [63:0] eaddr(input logic [63:0] base, input int idx);
        return base + 64'(idx) * 64'd8;
    endfunction

    function automatic logic [63:0] mk_leaf(input logic [5:0] f, input logic c,
        input logic [2:0] d, input logic [1:0] t, input logic [47:0] a, input logic v);
        return {f, c, d, t, 4'hA, a[47:8], 7'h55, v};
    endfunction

    // memory responder: decides ready and answers one negedge after the handshake
    always @(negedge clk) begin
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
            pend = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        if (rst_n && mem_req_valid) begin
            if (!seen) begin
                first_addr = mem_req_addr;
                seen = 1'b1;
                stall_left = stall_per;
            end else if (mem_req_addr !== first_addr) begin
                addr_moved = 1'b1;
            end
            if (stall_left > 0) begin
                mem_ready = 1'b0;
                stall_left--;
                stall_seen++;
            end else begin
                mem_ready = 1'b1;
                pend_addr = mem_req_addr;
                pend = 1'b1;
                seen = 1'b0;
                if (rd_cnt < 8) rd_log[rd_cnt] = mem_req_addr;
                rd_cnt++;
            end
        end else begin
            mem_ready = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string rq, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic send_req(input logic [47:0] va);
        logic acc;
        req_vaddr = va;
        req_valid = 1'b1;
        do begin
            acc = req_ready;
            @(negedge clk);
        end while (!acc);
        req_valid = 1'b0;
    endtask

    task automatic wait_res();
        while (!res_valid) @(negedge clk);
    endtask

    task automatic take_res();
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
    endtask

    task automatic walk(input logic [47:0] va);
        rd_cnt = 0;
        send_req(va);
        wait_res();
    endtask

    task automatic load_tables();
        mem[eaddr(tbl_base, 12'h123)] = 64'hABCD_0002_0000_FFFF;
        mem[eaddr(MB, 12'h456)]       = 64'h5A5A_0003_0000_7FFF;
        mem[eaddr(LB, 8'h78)]         = mk_leaf(6'h2D, 1'b1, 3'd5, 2'd1, 48'h7654_3210_0100, 1'b1);
        mem[eaddr(MB, 12'h001)]       = 64'h0000_0003_0000_6000;
        mem[eaddr(LB, 8'h10)]         = mk_leaf(6'h3F, 1'b1, 3'd7, 2'd1, 48'h1111_2222_3300, 1'b0);
        mem[eaddr(LB, 8'h20)]         = mk_leaf(6'h05, 1'b0, 3'd1, 2'd2, 48'h0000_4444_0000, 1'b1);
        mem[eaddr(LB, 8'h21)]         = mk_leaf(6'h06, 1'b1, 3'd2, 2'd3, 48'h0000_5555_0000, 1'b1);
        mem[eaddr(LB, 8'h22)]         = mk_leaf(6'h07, 1'b0, 3'd3, 2'd0, 48'h0000_6666_0000, 1'b1);
        mem[eaddr(tbl_base, 12'h800)] = 64'h0000_8000_0001_0001;
        mem[eaddr(MB2, 12'h012)]      = 64'h0000_8000_0002_0001;
        mem[eaddr(LB2, 8'h34)]        = mk_leaf(6'h11, 1'b0, 3'd2, 2'd0, 48'h0000_0ABC_DE00, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "res_valid", res_valid, 0);
        chk("R1", "mem_req_valid", mem_req_valid, 0);
    endtask

    task automatic t_hit();
        walk(48'h123_456_78_BEEF);
        chk("R2", "reads", rd_cnt, 3);
        chk("R2", "top read", rd_log[0], eaddr(tbl_base, 12'h123));
        chk("R3", "middle read", rd_log[1], eaddr(MB, 12'h456));
        chk("R4", "leaf read", rd_log[2], eaddr(LB, 8'h78));
        chk("R5", "aux", res_aux, 48'h7654_3210_0100);
        chk("R5", "fmt", res_fmt, 6'h2D);
        chk("R5", "chroma", res_chroma, 1);
        chk("R5", "depth", res_depth, 3'd5);
        chk("R5", "tile", res_tile, 2'd1);
        chk("R5", "level", res_level, 2);
        chk("R5", "miss/fault", {res_miss, res_fault}, 0);
        take_res();
        chk("R8", "ready after consume", {req_ready, res_valid}, 2'b10);
    endtask

    task automatic t_low_bits();
        walk(48'h123_456_78_0000);
        chk("R2", "low bits ignored leaf read", rd_log[2], eaddr(LB, 8'h78));
        chk("R2", "low bits ignored aux", res_aux, 48'h7654_3210_0100);
        take_res();
    endtask

    task automatic t_canon();
        walk(48'h800_012_34_0000);
        chk("R3", "canonical middle read", rd_log[1], eaddr(MB2, 12'h012));
        chk("R4", "canonical leaf read", rd_log[2], eaddr(LB2, 8'h34));
        chk("R5", "aux", res_aux, 48'h0000_0ABC_DE00);
        chk("R5", "fmt/depth", {res_fmt, res_depth}, {6'h11, 3'd2});
        take_res();
    endtask

    task automatic t_miss();
        walk(48'h001_000_00_0000);
        chk("R6", "top miss", {res_miss, res_fault, res_level}, {2'b10, 2'd0});
        chk("R6", "top miss reads", rd_cnt, 1);
        take_res();
        walk(48'h123_001_00_0000);
        chk("R6", "middle miss", {res_miss, res_fault, res_level}, {2'b10, 2'd1});
        chk("R6", "middle miss reads", rd_cnt, 2);
        take_res();
        walk(48'h123_456_10_0000);
        chk("R6", "leaf miss", {res_miss, res_fault, res_level}, {2'b10, 2'd2});
        chk("R6", "leaf miss reads", rd_cnt, 3);
        chk("R6", "leaf miss fields", {res_aux, res_fmt, res_tile}, 0);
        take_res();
    endtask

    task automatic t_fault();
        walk(48'h123_456_20_0000);
        chk("R7", "tile 2 fault", {res_miss, res_fault, res_level}, {2'b01, 2'd2});
        chk("R7", "tile 2 fields", {res_tile, res_aux}, {2'd2, 48'h0000_4444_0000});
        take_res();
        walk(48'h123_456_21_0000);
        chk("R7", "tile 3 fault", {res_miss, res_fault, res_tile}, {2'b01, 2'd3});
        take_res();
        walk(48'h123_456_22_0000);
        chk("R7", "tile 0 no fault", {res_miss, res_fault, res_tile}, {2'b00, 2'd0});
        take_res();
    endtask

    task automatic t_backpressure();
        walk(48'h123_456_78_0000);
        req_vaddr = 48'h800_012_34_0000;
        req_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R8", "held: req_ready", req_ready, 0);
            chk("R8", "held: result", {res_valid, res_aux, res_fmt}, {1'b1, 48'h7654_3210_0100, 6'h2D});
            chk("R8", "held: no reads", rd_cnt, 3);
        end
        rd_cnt = 0;
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk("R8", "released", {req_ready, res_valid}, 2'b10);
        @(negedge clk);
        req_valid = 1'b0;
        wait_res();
        chk("R8", "second walk middle read", rd_log[1], eaddr(MB2, 12'h012));
        chk("R8", "second walk aux", res_aux, 48'h0000_0ABC_DE00);
        take_res();
    endtask

    task automatic t_stall();
        stall_per = 3;
        stall_seen = 0;
        addr_moved = 1'b0;
        walk(48'h123_456_78_0000);
        stall_per = 0;
        chk("R9", "stalled reads", rd_cnt, 3);
        chk("R9", "stall cycles", stall_seen, 9);
        chk("R9", "address stable", addr_moved, 0);
        chk("R9", "leaf read", rd_log[2], eaddr(LB, 8'h78));
        chk("R9", "aux", res_aux, 48'h7654_3210_0100);
        take_res();
    endtask

    initial begin
        load_tables();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit();
        t_low_bits();
        t_canon();
        t_miss();
        t_fault();
        t_backpressure();
        t_stall();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule